// File: doc/BRIEF.md
# Display panel power sequencer

This controller brings an OLED panel and its driver chip up and down in a safe order. A power-up request switches on the logic supply and then, after a millisecond-scale gap, the high-voltage panel supply. It then pulses the driver reset (active low), lets the driver settle, and starts an external initialization engine. Once that engine reports done, it starts a display-memory clear engine. When the clear finishes, it hands a display-on register write to a bus writer over a valid/ready handshake.

A power-down request reverses the order. A display-off register write goes out first, then the high-voltage supply is dropped. The logic supply stays on through a long discharge wait so the panel can bleed off its charge. All waits are counted in pulses of a one-millisecond tick input. A power-down request that arrives while power-up is still running is remembered and acted on as soon as the panel reaches the on state.

Top module: `panel_power_seq`

## Requirements
- R1: While `rst_n` is low, and after reset, these outputs are all 0: `status`, `logic_en`, `hv_en`, `drv_rst_n`, `cmd_valid`, `init_start` and `clr_start`.
- R2: A power-up request taken in the off state sets `logic_en` on the next clock. `hv_en` follows after exactly T_LOGIC_MS tick pulses. The reset phase starts after a further T_HV_MS ticks.
- R3: `drv_rst_n` stays low whenever `hv_en` is low, and stays low for T_RST_MS ticks after the high-voltage wait ends. It then goes high, and T_SETTLE_MS ticks later `init_start` is raised.
- R4: The handshake with the two engines runs in this order:
  - `init_start` is a single-cycle pulse, and the block then waits for `init_done`.
  - Next, `clr_start` is a single-cycle pulse, and the block then waits for `clr_done`.
  - A done pulse that arrives outside its own wait is ignored.
- R5: After the clear is done, `cmd_valid` is raised with `cmd_addr` = 0x06 and `cmd_data` = 0x01 (display on). Address and data stay stable until `cmd_ready` is high. The cycle after acceptance, `status` reads ON.
- R6: A power-down request in the ON state raises `cmd_valid` with `cmd_addr` = 0x06 and `cmd_data` = 0x00 (display off). `hv_en` drops on the clock after that write is accepted.
- R7: After `hv_en` drops, `logic_en` stays high for exactly T_DISCH_MS tick pulses. It then drops and `status` returns to OFF.
- R8: A power-down request made at any point during power-up is held. The power-down sequence starts one cycle after the ON state is reached.
- R9: Some requests are ignored:
  - a power-up request while in ON or while powering down;
  - a power-down request while off.

  A power-up request seen during power-down is not retained.
- R10: `status` encodes the phase as follows: 0 = OFF, 1 = POWERING_UP, 2 = ON, 3 = POWERING_DOWN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| pwr_up_req | input | 1 | Power-up request pulse |
| pwr_dn_req | input | 1 | Power-down request pulse |
| logic_en | output | 1 | Logic supply enable |
| hv_en | output | 1 | High-voltage panel supply enable |
| drv_rst_n | output | 1 | Driver reset, active low |
| init_start | output | 1 | Start pulse to initialization engine |
| init_done | input | 1 | Initialization engine finished |
| clr_start | output | 1 | Start pulse to display-memory clear engine |
| clr_done | input | 1 | Clear engine finished |
| cmd_valid | output | 1 | Register write request to bus writer |
| cmd_ready | input | 1 | Bus writer accepts the write |
| cmd_addr | output | ADDR_W | Register address of the write |
| cmd_data | output | DATA_W | Register value of the write |
| status | output | 2 | Phase: 0 OFF, 1 POWERING_UP, 2 ON, 3 POWERING_DOWN |

## Verification
Every output is decoded from a single state register, so each result is due one clock after its cause:
- a request pulse, a done pulse or an accepted command moves the outputs on the next edge;
- a timed phase ends on the edge that samples its last millisecond tick;
- a start pulse is high during the first cycle of its wait state.

The bench drives every input for exactly one cycle from a falling edge and reads outputs at the following falling edge, half a cycle after the edge that changed them. Where a result takes a further cycle, such as the held power-down starting one cycle after ON is reached, it waits one more falling edge.

// File: rtl/panel_power_seq.sv
module panel_power_seq #(
  parameter int T_LOGIC_MS  = 1,
  parameter int T_HV_MS     = 1,
  parameter int T_RST_MS    = 1,
  parameter int T_SETTLE_MS = 5,
  parameter int T_DISCH_MS  = 100,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] DISP_REG     = 'h06,
  parameter logic [DATA_W-1:0] DISP_ON_VAL  = 'h01,
  parameter logic [DATA_W-1:0] DISP_OFF_VAL = 'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              pwr_up_req,
  input  logic              pwr_dn_req,
  output logic              logic_en,
  output logic              hv_en,
  output logic              drv_rst_n,
  output logic              init_start,
  input  logic              init_done,
  output logic              clr_start,
  input  logic              clr_done,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [1:0]        status
);

  localparam int M_A   = (T_LOGIC_MS > T_HV_MS) ? T_LOGIC_MS : T_HV_MS;
  localparam int M_B   = (T_RST_MS > T_SETTLE_MS) ? T_RST_MS : T_SETTLE_MS;
  localparam int M_C   = (M_A > M_B) ? M_A : M_B;
  localparam int T_MAX = (M_C > T_DISCH_MS) ? M_C : T_DISCH_MS;
  localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;

  localparam logic [1:0] ST_OFF  = 2'd0;
  localparam logic [1:0] ST_UP   = 2'd1;
  localparam logic [1:0] ST_ON   = 2'd2;
  localparam logic [1:0] ST_DOWN = 2'd3;

  typedef enum logic [3:0] {
    S_OFF, S_LOGIC, S_HV, S_RST, S_SETTLE, S_INIT,
    S_CLEAR, S_DON, S_ON, S_DOFF, S_DISCH
  } state_t;

  state_t           state, nxt;
  logic [CNT_W-1:0] cnt, t_last;
  logic             timed, t_hit, dn_pend;

  always_comb begin
    timed  = 1'b1;
    t_last = '0;
    case (state)
      S_LOGIC:  t_last = CNT_W'(T_LOGIC_MS - 1);
      S_HV:     t_last = CNT_W'(T_HV_MS - 1);
      S_RST:    t_last = CNT_W'(T_RST_MS - 1);
      S_SETTLE: t_last = CNT_W'(T_SETTLE_MS - 1);
      S_DISCH:  t_last = CNT_W'(T_DISCH_MS - 1);
      default:  timed  = 1'b0;
    endcase
  end

  assign t_hit = timed && ms_tick && (cnt == t_last);

  always_comb begin
    nxt = state;
    case (state)
      S_OFF:    if (pwr_up_req)            nxt = S_LOGIC;
      S_LOGIC:  if (t_hit)                 nxt = S_HV;
      S_HV:     if (t_hit)                 nxt = S_RST;
      S_RST:    if (t_hit)                 nxt = S_SETTLE;
      S_SETTLE: if (t_hit)                 nxt = S_INIT;
      S_INIT:   if (init_done)             nxt = S_CLEAR;
      S_CLEAR:  if (clr_done)              nxt = S_DON;
      S_DON:    if (cmd_ready)             nxt = S_ON;
      S_ON:     if (pwr_dn_req || dn_pend) nxt = S_DOFF;
      S_DOFF:   if (cmd_ready)             nxt = S_DISCH;
      S_DISCH:  if (t_hit)                 nxt = S_OFF;
      default:                             nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_OFF;
      cnt        <= '0;
      dn_pend    <= 1'b0;
      init_start <= 1'b0;
      clr_start  <= 1'b0;
    end else begin
      state      <= nxt;
      init_start <= (nxt == S_INIT)  && (state != S_INIT);
      clr_start  <= (nxt == S_CLEAR) && (state != S_CLEAR);
      if (nxt != state || !timed)
        cnt <= '0;
      else if (ms_tick)
        cnt <= cnt + 1'b1;
      if (state == S_ON)
        dn_pend <= 1'b0;
      else if (pwr_dn_req && status == ST_UP)
        dn_pend <= 1'b1;
    end
  end

  assign logic_en  = (state != S_OFF);
  assign hv_en     = logic_en && (state != S_LOGIC) && (state != S_DISCH);
  assign drv_rst_n = hv_en && (state != S_HV) && (state != S_RST);
  assign cmd_valid = (state == S_DON) || (state == S_DOFF);
  assign cmd_addr  = DISP_REG;
  assign cmd_data  = (state == S_DON) ? DISP_ON_VAL : DISP_OFF_VAL;

  always_comb begin
    case (state)
      S_OFF:           status = ST_OFF;
      S_ON:            status = ST_ON;
      S_DOFF, S_DISCH: status = ST_DOWN;
      default:         status = ST_UP;
    endcase
  end

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int DATA_W     = 8,
  parameter int T_DISCH_MS = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ms_tick,
  input logic              logic_en,
  input logic              hv_en,
  input logic              drv_rst_n,
  input logic              init_start,
  input logic              clr_start,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [DATA_W-1:0] cmd_data,
  input logic [1:0]        status
);

  logic [15:0] dis_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dis_cnt <= '0;
    else if (hv_en)
      dis_cnt <= '0;
    else if (ms_tick && logic_en && dis_cnt != 16'hFFFF)
      dis_cnt <= dis_cnt + 16'd1;
  end

  a_r2_hv_needs_logic: assert property (@(posedge clk) disable iff (!rst_n)
    hv_en |-> logic_en);

  a_r2_hv_after_logic: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_en) |-> $past(logic_en));

  a_r3_reset_while_hv_off: assert property (@(posedge clk) disable iff (!rst_n)
    drv_rst_n |-> hv_en);

  a_r4_init_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |-> drv_rst_n);

  a_r4_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({init_start, clr_start, cmd_valid}));

  a_r5_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  a_r6_hv_off_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hv_en) |-> $past(cmd_valid && cmd_ready));

  a_r7_discharge_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(logic_en) |-> (32'(dis_cnt) >= T_DISCH_MS));

  a_r10_on_status: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2) |-> (hv_en && drv_rst_n && !cmd_valid));

endmodule

bind panel_power_seq pps_checker #(.DATA_W(DATA_W), .T_DISCH_MS(T_DISCH_MS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .logic_en(logic_en), .hv_en(hv_en),
  .drv_rst_n(drv_rst_n), .init_start(init_start), .clr_start(clr_start),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data), .status(status)
);

// File: tb/tb_panel_power_seq.sv
module tb_panel_power_seq;
  logic clk = 0, rst_n = 0, ms_tick = 0, pwr_up_req = 0, pwr_dn_req = 0;
  logic init_done = 0, clr_done = 0, cmd_ready = 0;
  logic logic_en, hv_en, drv_rst_n, init_start, clr_start, cmd_valid;
  logic [7:0] cmd_addr, cmd_data;
  logic [1:0] status;
  int n_chk = 0, n_fail = 0, cyc = 0, n_init = 0, n_clr = 0, t_init = 0, t_clr = 0;

  always #5 clk = ~clk;

  panel_power_seq #(.T_LOGIC_MS(2), .T_HV_MS(2), .T_RST_MS(3), .T_SETTLE_MS(2),
                    .T_DISCH_MS(5)) dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_up_req(pwr_up_req),
    .pwr_dn_req(pwr_dn_req), .logic_en(logic_en), .hv_en(hv_en), .drv_rst_n(drv_rst_n),
    .init_start(init_start), .init_done(init_done), .clr_start(clr_start),
    .clr_done(clr_done), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .status(status));

  always @(negedge clk) begin
    cyc++;
    if (init_start) begin n_init++; t_init = cyc; end
    if (clr_start)  begin n_clr++;  t_clr  = cyc; end
  end

  typedef struct packed {
    logic [2:0] act; logic [3:0] n; logic [1:0] st;
    logic le; logic he; logic rn; logic cv; logic [7:0] cd;
  } vec_t;

  // act: 0 ticks, 1 init_done, 2 clr_done, 3 cmd accept, 4 up request, 5 down request
  localparam vec_t VEC [13] = '{
    '{3'd4, 4'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    '{3'd0, 4'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    '{3'd0, 4'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    '{3'd0, 4'd2, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    '{3'd0, 4'd3, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
    '{3'd0, 4'd2, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
    '{3'd1, 4'd0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
    '{3'd2, 4'd0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h01},
    '{3'd3, 4'd0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
    '{3'd5, 4'd0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00},
    '{3'd3, 4'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    '{3'd0, 4'd4, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    '{3'd0, 4'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) ms_tick = 1; @(negedge clk) ms_tick = 0;
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1; @(negedge clk) s = 0;
  endtask

  task automatic accept;
    repeat (3) @(negedge clk);
    chk("R5 command held while not ready", int'(cmd_valid), 1);
    pulse(cmd_ready);
  endtask

  task automatic bring_up;
    pulse(pwr_up_req); ticks(2); ticks(2); ticks(3); ticks(2);
    pulse(init_done); pulse(clr_done); pulse(cmd_ready);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int i0, c0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset enables", int'({logic_en, hv_en, drv_rst_n, cmd_valid}), 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk("R1 after reset starts", int'({init_start, clr_start}), 0);

    foreach (VEC[i]) begin
      case (VEC[i].act)
        3'd0: ticks(int'(VEC[i].n));
        3'd1: pulse(init_done);
        3'd2: pulse(clr_done);
        3'd3: accept();
        3'd4: pulse(pwr_up_req);
        default: pulse(pwr_dn_req);
      endcase
      chk($sformatf("R10 walk %0d status", i), int'(status), int'(VEC[i].st));
      chk($sformatf("R2 R7 walk %0d logic_en", i), int'(logic_en), int'(VEC[i].le));
      chk($sformatf("R2 R6 walk %0d hv_en", i), int'(hv_en), int'(VEC[i].he));
      chk($sformatf("R3 walk %0d drv_rst_n", i), int'(drv_rst_n), int'(VEC[i].rn));
      chk($sformatf("R5 R6 walk %0d cmd_valid", i), int'(cmd_valid), int'(VEC[i].cv));
      if (VEC[i].cv) begin
        chk($sformatf("R5 R6 walk %0d cmd_addr", i), int'(cmd_addr), 6);
        chk($sformatf("R5 R6 walk %0d cmd_data", i), int'(cmd_data), int'(VEC[i].cd));
      end
    end
    chk("R4 one init pulse", n_init, 1);
    chk("R4 one clear pulse", n_clr, 1);
    chk("R4 init before clear", int'(t_init < t_clr), 1);

    // R9: down request while off
    pulse(pwr_dn_req); repeat (2) @(negedge clk);
    chk("R9 down in OFF ignored", int'({status, logic_en}), 0);

    // R8 with R4: early down request, stray done pulses
    pulse(pwr_up_req); pulse(pwr_dn_req);
    chk("R8 still powering up", int'(status), 1);
    ticks(2); ticks(2); ticks(3);
    i0 = n_init; c0 = n_clr;
    pulse(init_done); pulse(clr_done);
    ticks(2); repeat (3) @(negedge clk);
    chk("R4 stray done ignored status", int'({status, cmd_valid}), 2);
    chk("R4 init pulsed once more", n_init - i0, 1);
    chk("R4 clear not started early", n_clr - c0, 0);
    pulse(init_done); pulse(clr_done); pulse(cmd_ready);
    chk("R8 reaches ON", int'(status), 2);
    @(negedge clk);
    chk("R8 held down request runs", int'(status), 3);
    chk("R6 display-off data", int'(cmd_data), 0);

    // R9: up request during power-down
    pulse(cmd_ready); pulse(pwr_up_req);
    chk("R9 up during down ignored", int'({status, hv_en}), 6);
    ticks(5); repeat (3) @(negedge clk);
    chk("R9 up during down not kept", int'({status, logic_en}), 0);

    // R9: up request in ON, then R1 mid-run reset
    bring_up();
    pulse(pwr_up_req); @(negedge clk);
    chk("R9 up in ON ignored", int'(status), 2);
    rst_n = 0; @(negedge clk);
    chk("R1 mid-run reset", int'({status, logic_en, hv_en, drv_rst_n, cmd_valid}), 0);
    report();
  end
endmodule